// File: doc/BRIEF.md
# USB Root Port Wake-Event Controller

This block keeps the status and change bits of one USB host root port and applies four wake-up events to them: a resume K-state, a device attach, a device detach and an over-current condition. Each event changes the port bits in its own way, depending on what state the port is in. Any accepted event raises a port-change flag. That flag drives an interrupt through an enable.

When the controller is not in its full-power state, an accepted event also sets a power-management status bit. An accepted event further raises a wake request, but only when that event's own wake enable is set. A resume always requests wake. In the full-power state only the interrupt path is active.

Software reaches the port through single-cycle strobes. The strobes enable the port, suspend it, end a running resume, and clear the change and power-management bits by write-one-to-clear. The event inputs are single-cycle pulses that are already synchronous to `clk`. The over-current input is a level, and its rising edge is the event.

Top module: `port_wake_ctrl`

## Requirements
- R1: A resume pulse while the port is suspended sets `port_fpr` and `port_change` one cycle later.
- R2: A resume pulse while the port is not suspended (disconnected, connected but disabled, or enabled and running) leaves every port bit and flag unchanged.
- R3: `sw_end_resume` while `port_fpr` is 1 clears both `port_fpr` and `port_suspended` on the next cycle.
- R4: A detach pulse while connected clears `port_connected`, `port_enabled`, `port_suspended` and `port_fpr`, and sets `conn_change` and `port_change`. A detach while disconnected is ignored.
- R5: An attach pulse while disconnected sets `port_connected`, `conn_change` and `port_change`. An attach while connected is ignored.
- R6: A rising edge of `oc_in` while connected sets `oc_active`, `oc_change` and `port_change`, and clears `port_enabled`, `port_suspended` and `port_fpr`. While disconnected the edge is ignored.
- R7: `oc_active` clears on the cycle after `oc_in` is seen low, while `oc_change` stays set until software clears it.
- R8: `port_irq` equals `port_change` AND `irq_en`. `sw_clr_pci` acknowledges the interrupt by clearing `port_change`.
- R9: `conn_change`, `oc_change`, `port_change` and `pme_status` are write-one-to-clear through their strobes. When a set and a clear of the same bit fall in one cycle, the bit ends up set.
- R10: When `pwr_state` differs from `FULL_PWR`, every accepted event sets `pme_status`. `pme_wake` is set only for a resume, for an attach with `wk_conn_en`, for a detach with `wk_disc_en`, or for an over-current with `wk_oc_en`. `sw_clr_pme` clears both bits.
- R11: While `pwr_state` equals `FULL_PWR`, events change neither `pme_status` nor `pme_wake`.
- R12: At most one event is accepted per cycle, with priority detach > over-current > attach > resume. In a cycle that accepts an event, the software port commands (`sw_port_enable`, `sw_port_suspend`, `sw_end_resume`) are ignored.
- R13: `sw_port_enable` sets `port_enabled` only while connected. `sw_port_suspend` sets `port_suspended` only while enabled.
- R14: Synchronous reset leaves the port disconnected, disabled and not suspended, with every flag, `oc_active`, `port_irq` and `pme_wake` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_resume_k | input | 1 | Resume K-state seen (pulse) |
| ev_connect | input | 1 | Device attach seen (pulse) |
| ev_disconnect | input | 1 | Device detach seen (pulse) |
| oc_in | input | 1 | Over-current level, synchronized |
| sw_port_enable | input | 1 | Software strobe: enable port |
| sw_port_suspend | input | 1 | Software strobe: suspend port |
| sw_end_resume | input | 1 | Software strobe: write zero to force-resume |
| sw_clr_csc | input | 1 | Clear strobe for `conn_change` |
| sw_clr_occ | input | 1 | Clear strobe for `oc_change` |
| sw_clr_pci | input | 1 | Clear strobe for `port_change` |
| sw_clr_pme | input | 1 | Clear strobe for `pme_status` and `pme_wake` |
| irq_en | input | 1 | Port-change interrupt enable |
| wk_conn_en | input | 1 | Wake enable for attach |
| wk_disc_en | input | 1 | Wake enable for detach |
| wk_oc_en | input | 1 | Wake enable for over-current |
| pwr_state | input | PWR_W | Controller power state |
| port_connected | output | 1 | Current connect status |
| port_enabled | output | 1 | Port enabled |
| port_suspended | output | 1 | Port suspended |
| port_fpr | output | 1 | Force-port-resume active |
| oc_active | output | 1 | Over-current active |
| conn_change | output | 1 | Connect status change |
| oc_change | output | 1 | Over-current change |
| port_change | output | 1 | Port-change status flag |
| port_irq | output | 1 | Interrupt request |
| pme_status | output | 1 | Power-management event status |
| pme_wake | output | 1 | Power-management wake request |

## Verification
The bench builds the block with `PWR_W = 2` and `FULL_PWR = 1`, not the default of 0. This means the power states 0, 2 and 3 all count as low power, so a decode that is hard-wired to state zero would be caught. With these values, a sweep of `pwr_state` passes through the full-power state and through low-power states on both sides of it, while events and wake enables vary at random.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int NUM_EV = 4;
    localparam int IX_RES  = 0;
    localparam int IX_CONN = 1;
    localparam int IX_DISC = 2;
    localparam int IX_OC   = 3;

    typedef struct packed {
        logic ccs;
        logic pe;
        logic susp;
        logic fpr;
        logic oca;
    } port_bits_t;

    typedef struct packed {
        logic resume;
        logic connect;
        logic disconnect;
        logic overcur;
    } ev_t;

    function automatic logic [NUM_EV-1:0] ev_vec(input ev_t e);
        logic [NUM_EV-1:0] v;
        v          = '0;
        v[IX_RES]  = e.resume;
        v[IX_CONN] = e.connect;
        v[IX_DISC] = e.disconnect;
        v[IX_OC]   = e.overcur;
        return v;
    endfunction

    function automatic logic [NUM_EV-1:0] wake_mask(input logic wkc, input logic wkd,
                                                    input logic wko);
        logic [NUM_EV-1:0] m;
        m          = '0;
        m[IX_RES]  = 1'b1;
        m[IX_CONN] = wkc;
        m[IX_DISC] = wkd;
        m[IX_OC]   = wko;
        return m;
    endfunction

    localparam port_bits_t PORT_RESET = '{ccs: 1'b0, pe: 1'b0, susp: 1'b0, fpr: 1'b0, oca: 1'b0};

endpackage

// File: rtl/pw_event_qual.sv
module pw_event_qual
    import pw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw_resume,
    input  logic raw_connect,
    input  logic raw_disconnect,
    input  logic oc_level,
    input  logic cur_ccs,
    input  logic cur_susp,
    output ev_t  acc
);
    logic oc_prev_q;
    logic oc_edge;

    always_ff @(posedge clk) begin
        if (rst) oc_prev_q <= 1'b0;
        else     oc_prev_q <= oc_level;
    end

    assign oc_edge = oc_level & ~oc_prev_q;

    always_comb begin
        acc            = '0;
        acc.disconnect = raw_disconnect & cur_ccs;
        acc.overcur    = oc_edge & cur_ccs & ~acc.disconnect;
        acc.connect    = raw_connect & ~cur_ccs;
        acc.resume     = raw_resume & cur_susp & ~acc.disconnect & ~acc.overcur;
    end

endmodule

// File: rtl/pw_port_state.sv
module pw_port_state
    import pw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ev_t        acc,
    input  logic       oc_level,
    input  logic       cmd_enable,
    input  logic       cmd_suspend,
    input  logic       cmd_end_resume,
    output port_bits_t pb
);
    port_bits_t pb_q;
    port_bits_t pb_d;
    logic       any_ev;

    assign any_ev = |ev_vec(acc);

    always_comb begin
        pb_d = pb_q;
        if (acc.disconnect) begin
            pb_d.ccs  = 1'b0;
            pb_d.pe   = 1'b0;
            pb_d.susp = 1'b0;
            pb_d.fpr  = 1'b0;
        end else if (acc.overcur) begin
            pb_d.pe   = 1'b0;
            pb_d.susp = 1'b0;
            pb_d.fpr  = 1'b0;
        end else if (acc.connect) begin
            pb_d.ccs  = 1'b1;
        end else if (acc.resume) begin
            pb_d.fpr  = 1'b1;
        end
        if (!any_ev) begin
            if (cmd_end_resume && pb_q.fpr) begin
                pb_d.fpr  = 1'b0;
                pb_d.susp = 1'b0;
            end else if (cmd_suspend && pb_q.pe) begin
                pb_d.susp = 1'b1;
            end
            if (cmd_enable && pb_q.ccs) pb_d.pe = 1'b1;
        end
        pb_d.oca = oc_level & (pb_q.oca | acc.overcur);
    end

    always_ff @(posedge clk) begin
        if (rst) pb_q <= PORT_RESET;
        else     pb_q <= pb_d;
    end

    assign pb = pb_q;

endmodule

// File: rtl/pw_change_flags.sv
module pw_change_flags
    import pw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ev_t  acc,
    input  logic clr_csc,
    input  logic clr_occ,
    input  logic clr_pci,
    input  logic irq_en,
    output logic csc,
    output logic occ,
    output logic pci,
    output logic irq
);
    logic csc_q, occ_q, pci_q;
    logic set_csc, set_occ, set_pci;

    assign set_csc = acc.connect | acc.disconnect;
    assign set_occ = acc.overcur;
    assign set_pci = |ev_vec(acc);

    always_ff @(posedge clk) begin
        if (rst) begin
            csc_q <= 1'b0;
            occ_q <= 1'b0;
            pci_q <= 1'b0;
        end else begin
            csc_q <= (csc_q & ~clr_csc) | set_csc;
            occ_q <= (occ_q & ~clr_occ) | set_occ;
            pci_q <= (pci_q & ~clr_pci) | set_pci;
        end
    end

    assign csc = csc_q;
    assign occ = occ_q;
    assign pci = pci_q;
    assign irq = pci_q & irq_en;

endmodule

// File: rtl/pw_pme.sv
module pw_pme
    import pw_pkg::*;
#(
    parameter int              PWR_W    = 2,
    parameter logic [PWR_W-1:0] FULL_PWR = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  ev_t              acc,
    input  logic [PWR_W-1:0] pwr_state,
    input  logic             wk_conn_en,
    input  logic             wk_disc_en,
    input  logic             wk_oc_en,
    input  logic             clr_pme,
    output logic             pme_sts,
    output logic             pme_req
);
    logic [NUM_EV-1:0] ev_bits;
    logic [NUM_EV-1:0] en_bits;
    logic [NUM_EV-1:0] hit;
    logic              low_pwr;
    logic              sts_q, req_q;

    assign ev_bits = ev_vec(acc);
    assign en_bits = wake_mask(wk_conn_en, wk_disc_en, wk_oc_en);
    assign low_pwr = (pwr_state != FULL_PWR);

    for (genvar g = 0; g < NUM_EV; g++) begin : g_gate
        assign hit[g] = ev_bits[g] & en_bits[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            sts_q <= (sts_q & ~clr_pme) | (low_pwr & (|ev_bits));
            req_q <= (req_q & ~clr_pme) | (low_pwr & (|hit));
        end
    end

    assign pme_sts = sts_q;
    assign pme_req = req_q;

endmodule

// File: rtl/port_wake_ctrl.sv
module port_wake_ctrl
    import pw_pkg::*;
#(
    parameter int               PWR_W    = 2,
    parameter logic [PWR_W-1:0] FULL_PWR = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_resume_k,
    input  logic             ev_connect,
    input  logic             ev_disconnect,
    input  logic             oc_in,
    input  logic             sw_port_enable,
    input  logic             sw_port_suspend,
    input  logic             sw_end_resume,
    input  logic             sw_clr_csc,
    input  logic             sw_clr_occ,
    input  logic             sw_clr_pci,
    input  logic             sw_clr_pme,
    input  logic             irq_en,
    input  logic             wk_conn_en,
    input  logic             wk_disc_en,
    input  logic             wk_oc_en,
    input  logic [PWR_W-1:0] pwr_state,
    output logic             port_connected,
    output logic             port_enabled,
    output logic             port_suspended,
    output logic             port_fpr,
    output logic             oc_active,
    output logic             conn_change,
    output logic             oc_change,
    output logic             port_change,
    output logic             port_irq,
    output logic             pme_status,
    output logic             pme_wake
);
    port_bits_t pb;
    ev_t        acc;

    pw_event_qual u_qual (
        .clk            (clk),
        .rst            (rst),
        .raw_resume     (ev_resume_k),
        .raw_connect    (ev_connect),
        .raw_disconnect (ev_disconnect),
        .oc_level       (oc_in),
        .cur_ccs        (pb.ccs),
        .cur_susp       (pb.susp),
        .acc            (acc)
    );

    pw_port_state u_state (
        .clk            (clk),
        .rst            (rst),
        .acc            (acc),
        .oc_level       (oc_in),
        .cmd_enable     (sw_port_enable),
        .cmd_suspend    (sw_port_suspend),
        .cmd_end_resume (sw_end_resume),
        .pb             (pb)
    );

    pw_change_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .clr_csc (sw_clr_csc),
        .clr_occ (sw_clr_occ),
        .clr_pci (sw_clr_pci),
        .irq_en  (irq_en),
        .csc     (conn_change),
        .occ     (oc_change),
        .pci     (port_change),
        .irq     (port_irq)
    );

    pw_pme #(
        .PWR_W    (PWR_W),
        .FULL_PWR (FULL_PWR)
    ) u_pme (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .pwr_state  (pwr_state),
        .wk_conn_en (wk_conn_en),
        .wk_disc_en (wk_disc_en),
        .wk_oc_en   (wk_oc_en),
        .clr_pme    (sw_clr_pme),
        .pme_sts    (pme_status),
        .pme_req    (pme_wake)
    );

    assign port_connected = pb.ccs;
    assign port_enabled   = pb.pe;
    assign port_suspended = pb.susp;
    assign port_fpr       = pb.fpr;
    assign oc_active      = pb.oca;

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
    parameter int               PWR_W    = 2,
    parameter logic [PWR_W-1:0] FULL_PWR = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_resume_k,
    input logic             ev_connect,
    input logic             ev_disconnect,
    input logic             oc_in,
    input logic             sw_end_resume,
    input logic             sw_clr_csc,
    input logic             irq_en,
    input logic [PWR_W-1:0] pwr_state,
    input logic             port_connected,
    input logic             port_enabled,
    input logic             port_suspended,
    input logic             port_fpr,
    input logic             oc_active,
    input logic             conn_change,
    input logic             port_change,
    input logic             port_irq,
    input logic             pme_wake
);
    AST_RESUME_SETS_FPR: assert property (@(posedge clk) disable iff (rst)
        (ev_resume_k && port_suspended && !ev_disconnect && !oc_in) |=> (port_fpr && port_change)); // R1

    AST_END_RESUME: assert property (@(posedge clk) disable iff (rst)
        (port_fpr && sw_end_resume && !ev_resume_k && !ev_disconnect && !oc_in)
        |=> (!port_fpr && !port_suspended)); // R3

    AST_DETACH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ev_disconnect && port_connected)
        |=> (!port_connected && !port_enabled && conn_change && port_change)); // R4

    AST_ATTACH_SETS: assert property (@(posedge clk) disable iff (rst)
        (ev_connect && !port_connected) |=> (port_connected && conn_change)); // R5

    AST_OCA_DROPS: assert property (@(posedge clk) disable iff (rst)
        !oc_in |=> !oc_active); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !port_irq); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (ev_connect && !port_connected && sw_clr_csc) |=> conn_change); // R9

    AST_NO_WAKE_FULL: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == FULL_PWR && !pme_wake) |=> !pme_wake); // R11

endmodule

bind port_wake_ctrl pw_checker #(
    .PWR_W    (PWR_W),
    .FULL_PWR (FULL_PWR)
) u_pw_checker (
    .clk            (clk),
    .rst            (rst),
    .ev_resume_k    (ev_resume_k),
    .ev_connect     (ev_connect),
    .ev_disconnect  (ev_disconnect),
    .oc_in          (oc_in),
    .sw_end_resume  (sw_end_resume),
    .sw_clr_csc     (sw_clr_csc),
    .irq_en         (irq_en),
    .pwr_state      (pwr_state),
    .port_connected (port_connected),
    .port_enabled   (port_enabled),
    .port_suspended (port_suspended),
    .port_fpr       (port_fpr),
    .oc_active      (oc_active),
    .conn_change    (conn_change),
    .port_change    (port_change),
    .port_irq       (port_irq),
    .pme_wake       (pme_wake)
);

// File: tb/port_wake_ctrl_bench.sv
module port_wake_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 2;
    localparam logic [PW-1:0] FULLP = 2'd1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_resume_k = 0, ev_connect = 0, ev_disconnect = 0, oc_in = 0;
    logic sw_port_enable = 0, sw_port_suspend = 0, sw_end_resume = 0;
    logic sw_clr_csc = 0, sw_clr_occ = 0, sw_clr_pci = 0, sw_clr_pme = 0;
    logic irq_en = 0, wk_conn_en = 0, wk_disc_en = 0, wk_oc_en = 0;
    logic [PW-1:0] pwr_state = FULLP;
    logic port_connected, port_enabled, port_suspended, port_fpr, oc_active;
    logic conn_change, oc_change, port_change, port_irq, pme_status, pme_wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_ccs, m_pe, m_susp, m_fpr, m_oca, m_csc, m_occ, m_pci, m_sts, m_wake, m_ocprev;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_wake_ctrl #(.PWR_W(PW), .FULL_PWR(FULLP)) u_port_wake_ctrl (
        .clk(clk), .rst(rst), .ev_resume_k(ev_resume_k), .ev_connect(ev_connect),
        .ev_disconnect(ev_disconnect), .oc_in(oc_in), .sw_port_enable(sw_port_enable),
        .sw_port_suspend(sw_port_suspend), .sw_end_resume(sw_end_resume),
        .sw_clr_csc(sw_clr_csc), .sw_clr_occ(sw_clr_occ), .sw_clr_pci(sw_clr_pci),
        .sw_clr_pme(sw_clr_pme), .irq_en(irq_en), .wk_conn_en(wk_conn_en),
        .wk_disc_en(wk_disc_en), .wk_oc_en(wk_oc_en), .pwr_state(pwr_state),
        .port_connected(port_connected), .port_enabled(port_enabled),
        .port_suspended(port_suspended), .port_fpr(port_fpr), .oc_active(oc_active),
        .conn_change(conn_change), .oc_change(oc_change), .port_change(port_change),
        .port_irq(port_irq), .pme_status(pme_status), .pme_wake(pme_wake)
    );

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, nm, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R5",  "port_connected", port_connected, m_ccs);
        chk("R13", "port_enabled",   port_enabled,   m_pe);
        chk("R3",  "port_suspended", port_suspended, m_susp);
        chk("R1",  "port_fpr",       port_fpr,       m_fpr);
        chk("R7",  "oc_active",      oc_active,      m_oca);
        chk("R4",  "conn_change",    conn_change,    m_csc);
        chk("R6",  "oc_change",      oc_change,      m_occ);
        chk("R8",  "port_change",    port_change,    m_pci);
        chk("R8",  "port_irq",       port_irq,       m_pci & irq_en);
        chk("R10", "pme_status",     pme_status,     m_sts);
        chk("R10", "pme_wake",       pme_wake,       m_wake);
    endtask

    // One clock: predict from inputs, advance, compare, drop pulses.
    task automatic cyc();
        bit edge_oc, a_d, a_o, a_c, a_r, any, lowp, wk;
        bit n_ccs, n_pe, n_susp, n_fpr, n_oca;
        edge_oc = oc_in && !m_ocprev;
        a_d = ev_disconnect && m_ccs;
        a_o = edge_oc && m_ccs && !a_d;
        a_c = ev_connect && !m_ccs;
        a_r = ev_resume_k && m_susp && !a_d && !a_o;
        any = a_d || a_o || a_c || a_r;
        lowp = (pwr_state != FULLP);
        wk = a_r || (a_c && wk_conn_en) || (a_d && wk_disc_en) || (a_o && wk_oc_en);
        n_ccs = m_ccs; n_pe = m_pe; n_susp = m_susp; n_fpr = m_fpr;
        if (a_d) begin n_ccs = 0; n_pe = 0; n_susp = 0; n_fpr = 0; end
        else if (a_o) begin n_pe = 0; n_susp = 0; n_fpr = 0; end
        else if (a_c) n_ccs = 1;
        else if (a_r) n_fpr = 1;
        else begin
            if (sw_end_resume && m_fpr) begin n_fpr = 0; n_susp = 0; end
            else if (sw_port_suspend && m_pe) n_susp = 1;
            if (sw_port_enable && m_ccs) n_pe = 1;
        end
        n_oca = oc_in && (m_oca || a_o);
        @(posedge clk);
        if (rst) begin
            {m_ccs, m_pe, m_susp, m_fpr, m_oca, m_csc, m_occ, m_pci, m_sts, m_wake, m_ocprev} = '0;
        end else begin
            m_csc  = (m_csc && !sw_clr_csc) || a_c || a_d;
            m_occ  = (m_occ && !sw_clr_occ) || a_o;
            m_pci  = (m_pci && !sw_clr_pci) || any;
            m_sts  = (m_sts && !sw_clr_pme) || (lowp && any);
            m_wake = (m_wake && !sw_clr_pme) || (lowp && wk);
            m_ccs = n_ccs; m_pe = n_pe; m_susp = n_susp; m_fpr = n_fpr; m_oca = n_oca;
            m_ocprev = oc_in;
        end
        @(negedge clk);
        compare_all();
        ev_resume_k = 0; ev_connect = 0; ev_disconnect = 0;
        sw_port_enable = 0; sw_port_suspend = 0; sw_end_resume = 0;
        sw_clr_csc = 0; sw_clr_occ = 0; sw_clr_pci = 0; sw_clr_pme = 0;
    endtask

    task automatic clr_all();
        sw_clr_csc = 1; sw_clr_occ = 1; sw_clr_pci = 1; sw_clr_pme = 1;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R14: reset state
        chk("R14", "rst connected", port_connected, 1'b0);
        chk("R14", "rst change", port_change, 1'b0);
        chk("R14", "rst wake", pme_wake, 1'b0);

        // R2: resume while disconnected
        ev_resume_k = 1; cyc();
        chk("R2", "resume on idle port", port_change, 1'b0);
        // R5: attach
        ev_connect = 1; cyc();
        chk("R5", "attach ccs", port_connected, 1'b1);
        chk("R5", "attach csc", conn_change, 1'b1);
        ev_connect = 1; clr_all();
        chk("R5", "attach while connected ignored", conn_change, 1'b0);
        // R2: resume while connected but disabled
        ev_resume_k = 1; cyc();
        chk("R2", "resume disabled fpr", port_fpr, 1'b0);
        chk("R2", "resume disabled pci", port_change, 1'b0);
        // R13 enable, resume while running
        sw_port_enable = 1; cyc();
        chk("R13", "enable", port_enabled, 1'b1);
        ev_resume_k = 1; cyc();
        chk("R2", "resume running", port_change, 1'b0);
        // R1 suspend then resume
        sw_port_suspend = 1; cyc();
        chk("R13", "suspend", port_suspended, 1'b1);
        ev_resume_k = 1; cyc();
        chk("R1", "resume sets fpr", port_fpr, 1'b1);
        chk("R1", "resume sets pci", port_change, 1'b1);
        // R3 end resume
        sw_end_resume = 1; cyc();
        chk("R3", "fpr cleared", port_fpr, 1'b0);
        chk("R3", "susp cleared", port_suspended, 1'b0);
        // R8 irq
        irq_en = 1; #1;
        chk("R8", "irq raised", port_irq, 1'b1);
        sw_clr_pci = 1; cyc();
        chk("R8", "irq acked", port_irq, 1'b0);
        // R6 over-current while enabled
        oc_in = 1; cyc();
        chk("R6", "oc clears pe", port_enabled, 1'b0);
        chk("R6", "occ set", oc_change, 1'b1);
        chk("R6", "oca set", oc_active, 1'b1);
        oc_in = 0; cyc();
        chk("R7", "oca drops", oc_active, 1'b0);
        chk("R7", "occ held", oc_change, 1'b1);
        // R9 set wins over clear; R4 detach
        clr_all();
        ev_disconnect = 1; sw_clr_csc = 1; cyc();
        chk("R9", "set wins csc", conn_change, 1'b1);
        chk("R4", "detach ccs", port_connected, 1'b0);
        clr_all();
        ev_disconnect = 1; cyc();
        chk("R4", "detach while disconnected ignored", conn_change, 1'b0);
        // R12: attach accepted, same-cycle enable ignored
        ev_connect = 1; sw_port_enable = 1; cyc();
        chk("R12", "enable ignored on event", port_enabled, 1'b0);
        sw_port_enable = 1; cyc();
        clr_all();
        // R12: detach beats over-current edge
        oc_in = 1; ev_disconnect = 1; cyc();
        chk("R12", "detach priority occ", oc_change, 1'b0);
        chk("R12", "detach priority csc", conn_change, 1'b1);
        oc_in = 0; cyc();
        clr_all();
        // R10 low power
        pwr_state = 2'd0; irq_en = 0;
        ev_connect = 1; cyc();
        chk("R10", "status without enable", pme_status, 1'b1);
        chk("R10", "no wake without enable", pme_wake, 1'b0);
        wk_disc_en = 1; ev_disconnect = 1; cyc();
        chk("R10", "wake with enable", pme_wake, 1'b1);
        clr_all();
        chk("R10", "pme cleared", pme_wake, 1'b0);
        // R11 full power
        pwr_state = FULLP; wk_conn_en = 1;
        ev_connect = 1; cyc();
        chk("R11", "no status full", pme_status, 1'b0);
        chk("R11", "no wake full", pme_wake, 1'b0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            ev_resume_k     = ($urandom_range(0, 5) == 0);
            ev_connect      = ($urandom_range(0, 7) == 0);
            ev_disconnect   = ($urandom_range(0, 11) == 0);
            if ($urandom_range(0, 9) == 0) oc_in = ~oc_in;
            sw_port_enable  = ($urandom_range(0, 3) == 0);
            sw_port_suspend = ($urandom_range(0, 4) == 0);
            sw_end_resume   = ($urandom_range(0, 4) == 0);
            sw_clr_csc      = ($urandom_range(0, 5) == 0);
            sw_clr_occ      = ($urandom_range(0, 5) == 0);
            sw_clr_pci      = ($urandom_range(0, 5) == 0);
            sw_clr_pme      = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) pwr_state = PW'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) begin
                irq_en = 1'($urandom); wk_conn_en = 1'($urandom);
                wk_disc_en = 1'($urandom); wk_oc_en = 1'($urandom);
            end
            cyc();
        end
        rst = 1; cyc();
        chk("R14", "reset again", port_connected | port_change | pme_status, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule